// File: doc/BRIEF.md
# Capture Input Glitch Filter

This block cleans up one asynchronous timer input before capture or edge logic sees it. The raw pin is brought into the timer clock domain through a two-flop synchronizer. A one-cycle sampling strobe then clocks a three-deep sample chain. The filtered level moves to a new value only when all three samples in the chain agree on it. Pulses shorter than that are treated as noise and dropped.

The sampling strobe comes from one free-running divider, so the whole block runs on a single clock. A two-bit filter rate select picks one of four sources: a slow prescaled rate, a medium prescaled rate, every clock, or the timer's count-source strobe. The count source has its own three-bit select. It can be a prescaled rate, or the rising edges of an external clock pin, which is synchronized and turned into an enable pulse.

A filter enable picks between the filtered level and the plain synchronized level. Whichever is chosen drives an edge detector with separate rise and fall pulse outputs. When any setting changes, the sample chain and the edge history are reloaded from the current synchronized level, so that the switch does not create an edge.

Top module: `cap_noise_filter`

## Requirements
- R1: While reset is asserted and after it is released, `lvl_out`, `rise_out` and `fall_out` are all 0 until the pin is driven high.
- R2: With `flt_en`=1, `lvl_out` takes a new level only after three consecutive sampling strobes all see that level. A pulse that spans only two strobes leaves `lvl_out` and the edge outputs unchanged.
- R3: With `flt_en`=1, the edge for an accepted transition appears no earlier than 2 strobe periods and no later than 5 strobe periods plus 4 clock cycles after the pin changes.
- R4: `flt_sel` sets the sampling strobe: 0 = every 32nd clock, 1 = every 8th clock, 2 = every clock, 3 = the count-source strobe.
- R5: `src_sel` sets the count-source strobe: 0 = every clock, 1 = every 2nd clock, 2 = every 4th, 3 = every 8th, 4 = every 32nd, 5 = each rising edge of `ext_clk_in`. Codes 6 and 7 give no strobe, so the filtered level holds.
- R6: With `src_sel`=5 and `flt_sel`=3, each synchronized rising edge of `ext_clk_in` gives one sample. If `ext_clk_in` is stopped, no transition is accepted.
- R7: With `flt_en`=0, the pin passes through two synchronizer flops only. A change reaches `rise_out` or `fall_out` within 4 clock cycles, and a single-cycle pin pulse yields one rise and one fall.
- R8: `rise_out` pulses for one cycle, in the cycle after `lvl_out` goes 0 to 1. `fall_out` does the same for 1 to 0. The two outputs are never high together.
- R9: A change of `flt_en`, `flt_sel` or `src_sel` reloads the sample chain, the filtered level and the edge history from the synchronized pin level. No edge is reported in the cycle after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw asynchronous timer input |
| ext_clk_in | input | 1 | Raw external count clock, used when `src_sel`=5 |
| src_sel | input | 3 | Count-source strobe select |
| flt_sel | input | 2 | Sampling strobe select |
| flt_en | input | 1 | 1 = filtered path, 0 = synchronized-only path |
| lvl_out | output | 1 | Selected conditioned level |
| rise_out | output | 1 | One-cycle pulse on a 0-to-1 change of `lvl_out` |
| fall_out | output | 1 | One-cycle pulse on a 1-to-0 change of `lvl_out` |

## Verification
The bench sweeps every valid strobe source, including the external clock. For each one it measures rise and fall latency against both bounds, so a divider with the wrong ratio or a match depth other than three shows up as a latency outside the window. It also sends a pulse exactly two strobe periods wide, which a correct filter must reject and a two-sample filter would pass. A stopped external clock and an unused count-source code must freeze the filter; a strobe that leaks through would let the held pin pass. Switching from bypass to filtering while the pin is high, before the filter has caught up, would produce a spurious fall and rise in a design without the reload.

// File: rtl/tnf_pkg.sv
`timescale 1ns/1ps
package tnf_pkg;
  typedef enum logic [1:0] {
    FS_SLOW  = 2'd0,
    FS_MID   = 2'd1,
    FS_FULL  = 2'd2,
    FS_COUNT = 2'd3
  } flt_sel_e;

  typedef enum logic [2:0] {
    CS_DIV1  = 3'd0,
    CS_DIV2  = 3'd1,
    CS_DIV4  = 3'd2,
    CS_DIV8  = 3'd3,
    CS_DIV32 = 3'd4,
    CS_EXT   = 3'd5,
    CS_RSV6  = 3'd6,
    CS_RSV7  = 3'd7
  } cnt_src_e;

  typedef struct packed {
    logic       en;
    logic [1:0] fs;
    logic [2:0] cs;
  } tnf_cfg_t;
endpackage

// File: rtl/tnf_sync.sv
`timescale 1ns/1ps
module tnf_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic q_out
);
  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb ff_d = d_in;
    end else begin : g_many
      always_comb ff_d = {ff_q[STAGES-2:0], d_in};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= '0;
    else        ff_q <= ff_d;
  end

  assign q_out = ff_q[STAGES-1];
endmodule

// File: rtl/tnf_strobe_gen.sv
`timescale 1ns/1ps
module tnf_strobe_gen
  import tnf_pkg::*;
#(
  parameter int unsigned DIV_MAX = 32,
  parameter int unsigned DIV_FS0 = 32,
  parameter int unsigned DIV_FS1 = 8,
  parameter int unsigned DIV_CS1 = 2,
  parameter int unsigned DIV_CS2 = 4,
  parameter int unsigned DIV_CS3 = 8,
  parameter int unsigned DIV_CS4 = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] src_sel,
  input  logic [1:0] flt_sel,
  input  logic       ext_lvl,
  output logic       smp_stb
);
  localparam int unsigned CW = $clog2(DIV_MAX);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          ext_q, ext_d;
  logic          ext_stb;
  logic          cs_stb;

  function automatic logic tick(input logic [CW-1:0] c, input int unsigned d);
    logic [CW-1:0] m;
    m = CW'(d - 1);
    return (c & m) == m;
  endfunction

  always_comb begin
    cnt_d   = cnt_q + 1'b1;
    ext_d   = ext_lvl;
    ext_stb = ext_lvl & ~ext_q;
  end

  always_comb begin
    unique case (cnt_src_e'(src_sel))
      CS_DIV1:  cs_stb = 1'b1;
      CS_DIV2:  cs_stb = tick(cnt_q, DIV_CS1);
      CS_DIV4:  cs_stb = tick(cnt_q, DIV_CS2);
      CS_DIV8:  cs_stb = tick(cnt_q, DIV_CS3);
      CS_DIV32: cs_stb = tick(cnt_q, DIV_CS4);
      CS_EXT:   cs_stb = ext_stb;
      default:  cs_stb = 1'b0;
    endcase
  end

  always_comb begin
    unique case (flt_sel_e'(flt_sel))
      FS_SLOW:  smp_stb = tick(cnt_q, DIV_FS0);
      FS_MID:   smp_stb = tick(cnt_q, DIV_FS1);
      FS_FULL:  smp_stb = 1'b1;
      default:  smp_stb = cs_stb;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ext_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ext_q <= ext_d;
    end
  end
endmodule

// File: rtl/tnf_match.sv
`timescale 1ns/1ps
module tnf_match #(
  parameter int unsigned TAPS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic stb,
  input  logic reload,
  output logic lvl
);
  logic [TAPS-1:0] chain_q, chain_d;
  logic            lvl_q, lvl_d;

  always_comb begin
    chain_d = chain_q;
    lvl_d   = lvl_q;
    if (reload) begin
      chain_d = {TAPS{din}};
      lvl_d   = din;
    end else begin
      if (stb) chain_d = {chain_q[TAPS-2:0], din};
      if (&chain_q)       lvl_d = 1'b1;
      else if (~|chain_q) lvl_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      lvl_q   <= 1'b0;
    end else begin
      chain_q <= chain_d;
      lvl_q   <= lvl_d;
    end
  end

  assign lvl = lvl_q;
endmodule

// File: rtl/tnf_edge.sv
`timescale 1ns/1ps
module tnf_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic resync,
  input  logic resync_lvl,
  output logic rise,
  output logic fall
);
  logic prev_q, prev_d;
  logic rise_q, rise_d;
  logic fall_q, fall_d;

  always_comb begin
    if (resync) begin
      prev_d = resync_lvl;
      rise_d = 1'b0;
      fall_d = 1'b0;
    end else begin
      prev_d = lvl;
      rise_d = lvl & ~prev_q;
      fall_d = ~lvl & prev_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign rise = rise_q;
  assign fall = fall_q;
endmodule

// File: rtl/cap_noise_filter.sv
`timescale 1ns/1ps
module cap_noise_filter
  import tnf_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MATCH_TAPS  = 3,
  parameter int unsigned DIV_MAX     = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_in,
  input  logic       ext_clk_in,
  input  logic [2:0] src_sel,
  input  logic [1:0] flt_sel,
  input  logic       flt_en,
  output logic       lvl_out,
  output logic       rise_out,
  output logic       fall_out
);
  tnf_cfg_t cfg_in, cfg_q;
  logic     reload;
  logic     pin_s, ext_s, smp_stb, flt_lvl, sel_lvl;

  always_comb begin
    cfg_in.en = flt_en;
    cfg_in.fs = flt_sel;
    cfg_in.cs = src_sel;
    reload    = (cfg_in != cfg_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_in;
  end

  tnf_sync #(.STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .q_out(pin_s));

  tnf_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d_in(ext_clk_in), .q_out(ext_s));

  tnf_strobe_gen #(.DIV_MAX(DIV_MAX)) u_stb (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .flt_sel(flt_sel),
    .ext_lvl(ext_s), .smp_stb(smp_stb));

  tnf_match #(.TAPS(MATCH_TAPS)) u_match (
    .clk(clk), .rst_n(rst_n), .din(pin_s), .stb(smp_stb),
    .reload(reload), .lvl(flt_lvl));

  always_comb sel_lvl = cfg_q.en ? flt_lvl : pin_s;

  tnf_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(sel_lvl), .resync(reload),
    .resync_lvl(pin_s), .rise(rise_out), .fall(fall_out));

  assign lvl_out = sel_lvl;
endmodule

// File: rtl/tnf_checker.sv
`timescale 1ns/1ps
module tnf_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] src_sel,
  input logic [1:0] flt_sel,
  input logic       flt_en,
  input logic       lvl_out,
  input logic       rise_out,
  input logic       fall_out
);
  p_quiet_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (!lvl_out && !rise_out && !fall_out));

  p_edges_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_out && fall_out));

  p_rise_follows_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rise_out |-> $past(lvl_out));

  p_fall_follows_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_out |-> !$past(lvl_out));

  p_no_edge_on_cfg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({flt_en, flt_sel, src_sel} != $past({flt_en, flt_sel, src_sel}))
      |=> (!rise_out && !fall_out));
endmodule

bind cap_noise_filter tnf_checker u_chk (
  .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .flt_sel(flt_sel),
  .flt_en(flt_en), .lvl_out(lvl_out), .rise_out(rise_out), .fall_out(fall_out));

// File: tb/sim_cap_noise_filter.sv
`timescale 1ns/1ps
module sim_cap_noise_filter;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       pin_in;
  logic       ext_clk_in;
  logic       ext_run;
  logic [2:0] src_sel;
  logic [1:0] flt_sel;
  logic       flt_en;
  logic       lvl_out, rise_out, fall_out;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  cap_noise_filter u0 (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .ext_clk_in(ext_clk_in),
    .src_sel(src_sel), .flt_sel(flt_sel), .flt_en(flt_en),
    .lvl_out(lvl_out), .rise_out(rise_out), .fall_out(fall_out));

  initial begin
    ext_clk_in = 1'b0;
    #1;
    forever begin
      #24;
      if (ext_run) ext_clk_in = ~ext_clk_in;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic en, input logic [1:0] fs, input logic [2:0] cs);
    flt_en = en; flt_sel = fs; src_sel = cs;
    repeat (4) @(negedge clk);
  endtask

  task automatic edge_test(input logic lvl, input int p, input int lo, input int hi,
                           input string req);
    int n_want = 0;
    int n_other = 0;
    int first = -1;
    pin_in = lvl;
    for (int c = 1; c <= 6 * p + 10; c++) begin
      @(negedge clk);
      if (lvl ? rise_out : fall_out) begin
        n_want++;
        if (first < 0) first = c;
      end
      if (lvl ? fall_out : rise_out) n_other++;
    end
    check(n_want == 1, req, "wanted edge count", n_want, 1);
    check(n_other == 0, "R8", "opposite edge count", n_other, 0);
    check(first >= lo && first <= hi, "R3", "edge latency upper bound", first, hi);
    check(first >= lo, "R3", "edge latency lower bound", first, lo);
    check(lvl_out == lvl, req, "settled level", int'(lvl_out), int'(lvl));
  endtask

  task automatic glitch_test(input int p, input string req);
    int n_e = 0;
    pin_in = 1'b1;
    for (int c = 0; c < 2 * p; c++) begin
      @(negedge clk);
      if (rise_out || fall_out) n_e++;
    end
    pin_in = 1'b0;
    for (int c = 0; c < 6 * p + 10; c++) begin
      @(negedge clk);
      if (rise_out || fall_out) n_e++;
    end
    check(n_e == 0, req, "R2 two-strobe pulse edges", n_e, 0);
    check(lvl_out == 1'b0, req, "R2 level after two-strobe pulse", int'(lvl_out), 0);
  endtask

  task automatic hold_test(input string req, input string what);
    int n_e = 0;
    pin_in = 1'b1;
    for (int c = 0; c < 200; c++) begin
      @(negedge clk);
      if (rise_out || fall_out) n_e++;
    end
    check(n_e == 0 && lvl_out == 1'b0, req, what, n_e + int'(lvl_out), 0);
    pin_in = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog expired: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pin_in = 1'b0; ext_run = 1'b1;
    flt_en = 1'b1; flt_sel = 2'd2; src_sel = 3'd0;
    repeat (3) @(negedge clk);
    check(!lvl_out && !rise_out && !fall_out, "R1", "outputs in reset",
          int'({lvl_out, rise_out, fall_out}), 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(!lvl_out && !rise_out && !fall_out, "R1", "outputs after release",
          int'({lvl_out, rise_out, fall_out}), 0);

    // R4 / R5 / R6 sweep over every valid strobe source
    for (int k = 0; k < 9; k++) begin
      logic [1:0] fs;
      logic [2:0] cs;
      int p;
      string req;
      if (k < 3) begin
        fs = 2'(k); cs = 3'd0; req = "R4";
        p = (k == 0) ? 32 : (k == 1) ? 8 : 1;
      end else begin
        fs = 2'd3; cs = 3'(k - 3); req = (k == 8) ? "R6" : "R5";
        case (k - 3)
          0: p = 1;
          1: p = 2;
          2: p = 4;
          3: p = 8;
          4: p = 32;
          default: p = 12;
        endcase
      end
      set_cfg(1'b1, fs, cs);
      edge_test(1'b1, p, 2 * p, 5 * p + 4, req);
      edge_test(1'b0, p, 2 * p, 5 * p + 4, req);
      glitch_test(p, req);
    end

    // R6: stopped external clock freezes the filter
    ext_run = 1'b0;
    set_cfg(1'b1, 2'd3, 3'd5);
    hold_test("R6", "edges+level with stopped ext clock");
    ext_run = 1'b1;

    // R5: reserved count-source code gives no strobe
    set_cfg(1'b1, 2'd3, 3'd6);
    hold_test("R5", "edges+level with reserved source code");

    // R7: bypass path
    set_cfg(1'b0, 2'd0, 3'd0);
    edge_test(1'b1, 0, 1, 4, "R7");
    edge_test(1'b0, 0, 1, 4, "R7");
    begin
      int nr = 0;
      int nf = 0;
      pin_in = 1'b1;
      @(negedge clk);
      pin_in = 1'b0;
      for (int c = 0; c < 10; c++) begin
        @(negedge clk);
        if (rise_out) nr++;
        if (fall_out) nf++;
      end
      check(nr == 1, "R7", "single-cycle pulse rises", nr, 1);
      check(nf == 1, "R7", "single-cycle pulse falls", nf, 1);
    end

    // R9: enabling the slow filter while the pin is high
    begin
      int n_e = 0;
      pin_in = 1'b1;
      repeat (6) @(negedge clk);
      check(lvl_out == 1'b1, "R9", "bypass level before switch", int'(lvl_out), 1);
      flt_en = 1'b1;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (rise_out || fall_out) n_e++;
        if (c == 20) flt_sel = 2'd1;
      end
      check(n_e == 0, "R9", "edges after setting change", n_e, 0);
      check(lvl_out == 1'b1, "R9", "level after setting change", int'(lvl_out), 1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule